// File: doc/BRIEF.md
# Indirect SDRAM configuration register file

This block is the configuration store of an SDRAM memory controller, reached from the CPU through only two device-control addresses. One address is an index register. The other is a data window that reads or writes whichever internal register the index currently holds. Inside are two bus-error status words, an error address, a global configuration word with a status word that follows it, a refresh timing word, a power-management idle timer, an ECC configuration word, an ECC error status word and four bank configuration words.

The global enable bit and the four bank words leave the block continuously for the address decoder. An interrupt line reports a nonzero ECC error status. Hardware error logic marks bus errors through two bit-set inputs. The register port carries no streaming data and has no back-pressure: every access finishes in the cycle it is presented. Reads are combinational from the address and the held index. A write takes effect on the rising clock edge in which the write strobe is high. Reset is synchronous and active high.

Top module: `sdram_cfg_regfile`

## Requirements
- R1: Port address 0x010 is the index register: a write stores all 32 bits and a read returns them. Reads at any port address other than 0x010 and 0x011 return zero. Writes there change nothing.
- R2: Port address 0x011 is the window to the internal register at the index. The two bus-error status words sit at offsets 0x00 and 0x08. A window write clears the bits that are set in the written data. A bit pulsed on err_set_a or err_set_b sets the matching bit, and a set wins over a clear in the same cycle. The error address at offset 0x10 is plain read/write.
- R3: The configuration word at offset 0x20 keeps only bits 31:21 of a write. Its bit 31 drives mem_enable from the cycle after the write.
- R4: The status word at offset 0x24 ignores writes. When configuration bit 31 goes 0 to 1, status bit 31 is cleared; when it goes 1 to 0, status bit 31 is set. When configuration bit 30 goes 0 to 1, status bit 30 is set; when it goes 1 to 0, status bit 30 is cleared.
- R5: The refresh word at offset 0x30 keeps a write ANDed with 0x3FF80000. The ECC configuration word at offset 0x94 keeps a write ANDed with 0x00F00000.
- R6: The idle timer at offset 0x34 keeps bits 31:27 of a write, and its bits 26:0 always read 0x07C00000.
- R7: The ECC error status at offset 0x98 keeps a write ANDed with 0xFFF0F000. ecc_irq rises when a write moves it from zero to nonzero, falls when a write moves it from nonzero to zero, and otherwise holds.
- R8: After reset, configuration reads 0x00800000, refresh reads 0x05F00000, idle timer reads 0x07C00000, and the index and every other register read zero.
- R9: A window read at the timing offset 0x80, or at any offset not listed here, returns 0xFFFFFFFF. A window write there changes no register.
- R10: Bank word i (offset 0x40 + 4*i, i = 0..3) keeps a write ANDed with 0xFFDEE001. It reads back through the window and appears on bank_cfg bits 32*i+31 : 32*i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dcr_addr | input | 10 | Device-control address (0x010 index, 0x011 window) |
| dcr_wr | input | 1 | Write strobe, sampled on the rising edge |
| dcr_wdata | input | 32 | Write data |
| dcr_rdata | output | 32 | Combinational read data |
| err_set_a | input | 32 | Bits to set in bus-error status word A |
| err_set_b | input | 32 | Bits to set in bus-error status word B |
| ecc_irq | output | 1 | ECC error interrupt |
| mem_enable | output | 1 | Global memory enable (configuration bit 31) |
| bank_cfg | output | 128 | Four bank configuration words, bank 0 in the low bits |

## Verification
A bad index shows at the next window read as data from the wrong register, or as all ones. A wrong bank word or enable bit is visible on bank_cfg or mem_enable one cycle after the faulty write. The interrupt flop is kept apart from the ECC status word, so the two can drift out of step. That shows as ecc_irq disagreeing with the ECC status read back in the same cycle. Status edge tracking is observed only through window reads after each configuration write, so a missed edge shows on the first status read that follows it.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
  localparam int unsigned REG_W = 32;

  localparam logic [REG_W-1:0] OFF_ERRST_A = 32'h00;
  localparam logic [REG_W-1:0] OFF_ERRST_B = 32'h08;
  localparam logic [REG_W-1:0] OFF_ERRADR  = 32'h10;
  localparam logic [REG_W-1:0] OFF_GCFG    = 32'h20;
  localparam logic [REG_W-1:0] OFF_GSTAT   = 32'h24;
  localparam logic [REG_W-1:0] OFF_RFSH    = 32'h30;
  localparam logic [REG_W-1:0] OFF_IDLE    = 32'h34;
  localparam logic [REG_W-1:0] OFF_BANK0   = 32'h40;
  localparam logic [REG_W-1:0] BANK_STRIDE = 32'h04;
  localparam logic [REG_W-1:0] OFF_TIMING  = 32'h80;
  localparam logic [REG_W-1:0] OFF_ECCCFG  = 32'h94;
  localparam logic [REG_W-1:0] OFF_ECCERR  = 32'h98;

  localparam logic [REG_W-1:0] GCFG_MASK   = 32'hFFE0_0000;
  localparam logic [REG_W-1:0] RFSH_MASK   = 32'h3FF8_0000;
  localparam logic [REG_W-1:0] IDLE_KEEP   = 32'hF800_0000;
  localparam logic [REG_W-1:0] IDLE_FORCE  = 32'h07C0_0000;
  localparam logic [REG_W-1:0] ECCCFG_MASK = 32'h00F0_0000;
  localparam logic [REG_W-1:0] ECCERR_MASK = 32'hFFF0_F000;
  localparam logic [REG_W-1:0] BANK_MASK   = 32'hFFDE_E001;

  localparam logic [REG_W-1:0] GCFG_RST    = 32'h0080_0000;
  localparam logic [REG_W-1:0] RFSH_RST    = 32'h05F0_0000;
  localparam logic [REG_W-1:0] IDLE_RST    = 32'h07C0_0000;

  localparam int unsigned EN_BIT  = 31;
  localparam int unsigned AUX_BIT = 30;

  typedef struct packed {
    logic errst_a;
    logic errst_b;
    logic erradr;
    logic gcfg;
    logic gstat;
    logic rfsh;
    logic idle;
    logic timing;
    logic ecccfg;
    logic eccerr;
  } fix_sel_t;
endpackage

// File: rtl/sdram_cfg_decode.sv
module sdram_cfg_decode
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic [REG_W-1:0]     idx,
  output fix_sel_t             sel,
  output logic [NUM_BANKS-1:0] bank_hit
);
  always_comb begin
    sel         = '0;
    sel.errst_a = (idx == OFF_ERRST_A);
    sel.errst_b = (idx == OFF_ERRST_B);
    sel.erradr  = (idx == OFF_ERRADR);
    sel.gcfg    = (idx == OFF_GCFG);
    sel.gstat   = (idx == OFF_GSTAT);
    sel.rfsh    = (idx == OFF_RFSH);
    sel.idle    = (idx == OFF_IDLE);
    sel.timing  = (idx == OFF_TIMING);
    sel.ecccfg  = (idx == OFF_ECCCFG);
    sel.eccerr  = (idx == OFF_ECCERR);
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank_dec
    localparam logic [REG_W-1:0] BANK_OFF = OFF_BANK0 + BANK_STRIDE * REG_W'(g);
    assign bank_hit[g] = (idx == BANK_OFF);
  end
endmodule

// File: rtl/sdram_cfg_ctrl.sv
module sdram_cfg_ctrl
  import sdram_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  fix_sel_t         sel,
  input  logic [REG_W-1:0] err_set_a,
  input  logic [REG_W-1:0] err_set_b,
  output logic [REG_W-1:0] errst_a_q,
  output logic [REG_W-1:0] errst_b_q,
  output logic [REG_W-1:0] erradr_q,
  output logic [REG_W-1:0] gcfg_q,
  output logic [REG_W-1:0] gstat_q,
  output logic [REG_W-1:0] rfsh_q,
  output logic [REG_W-1:0] idle_q,
  output logic [REG_W-1:0] ecccfg_q,
  output logic [REG_W-1:0] eccerr_q,
  output logic             irq_q
);
  logic [REG_W-1:0] cfg_new;
  logic [REG_W-1:0] ecc_new;
  logic [REG_W-1:0] clr_a;
  logic [REG_W-1:0] clr_b;

  assign cfg_new = wdata & GCFG_MASK;
  assign ecc_new = wdata & ECCERR_MASK;
  assign clr_a   = (wr_en && sel.errst_a) ? wdata : '0;
  assign clr_b   = (wr_en && sel.errst_b) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      errst_a_q <= '0;
      errst_b_q <= '0;
      erradr_q  <= '0;
      gcfg_q    <= GCFG_RST;
      gstat_q   <= '0;
      rfsh_q    <= RFSH_RST;
      idle_q    <= IDLE_RST;
      ecccfg_q  <= '0;
      eccerr_q  <= '0;
      irq_q     <= 1'b0;
    end else begin
      errst_a_q <= (errst_a_q & ~clr_a) | err_set_a;
      errst_b_q <= (errst_b_q & ~clr_b) | err_set_b;
      if (wr_en && sel.erradr) erradr_q <= wdata;
      if (wr_en && sel.rfsh)   rfsh_q   <= wdata & RFSH_MASK;
      if (wr_en && sel.idle)   idle_q   <= (wdata & IDLE_KEEP) | IDLE_FORCE;
      if (wr_en && sel.ecccfg) ecccfg_q <= wdata & ECCCFG_MASK;
      if (wr_en && sel.gcfg) begin
        gcfg_q <= cfg_new;
        if (!gcfg_q[EN_BIT] && cfg_new[EN_BIT])      gstat_q[EN_BIT] <= 1'b0;
        else if (gcfg_q[EN_BIT] && !cfg_new[EN_BIT]) gstat_q[EN_BIT] <= 1'b1;
        if (!gcfg_q[AUX_BIT] && cfg_new[AUX_BIT])      gstat_q[AUX_BIT] <= 1'b1;
        else if (gcfg_q[AUX_BIT] && !cfg_new[AUX_BIT]) gstat_q[AUX_BIT] <= 1'b0;
      end
      if (wr_en && sel.eccerr) begin
        eccerr_q <= ecc_new;
        if (eccerr_q == '0 && ecc_new != '0)      irq_q <= 1'b1;
        else if (eccerr_q != '0 && ecc_new == '0) irq_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdram_cfg_banks.sv
module sdram_cfg_banks
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [REG_W-1:0]                 wdata,
  input  logic [NUM_BANKS-1:0]             bank_hit,
  output logic [NUM_BANKS-1:0][REG_W-1:0]  bank_q
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                        bank_q[g] <= '0;
      else if (wr_en && bank_hit[g])  bank_q[g] <= wdata & BANK_MASK;
    end
  end
endmodule

// File: rtl/sdram_cfg_regfile.sv
module sdram_cfg_regfile
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned AW        = 10,
  parameter logic [AW-1:0] IDX_ADDR = 10'h010,
  parameter logic [AW-1:0] WIN_ADDR = 10'h011
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [AW-1:0]              dcr_addr,
  input  logic                       dcr_wr,
  input  logic [REG_W-1:0]           dcr_wdata,
  output logic [REG_W-1:0]           dcr_rdata,
  input  logic [REG_W-1:0]           err_set_a,
  input  logic [REG_W-1:0]           err_set_b,
  output logic                       ecc_irq,
  output logic                       mem_enable,
  output logic [NUM_BANKS*REG_W-1:0] bank_cfg
);
  logic [REG_W-1:0] idx_q;
  logic             idx_wr;
  logic             win_wr;
  fix_sel_t         sel;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [NUM_BANKS-1:0][REG_W-1:0] bank_q;
  logic [REG_W-1:0] errst_a_q, errst_b_q, erradr_q, gcfg_q, gstat_q;
  logic [REG_W-1:0] rfsh_q, idle_q, ecccfg_q, eccerr_q;
  logic [REG_W-1:0] win_data;

  assign idx_wr = dcr_wr && (dcr_addr == IDX_ADDR);
  assign win_wr = dcr_wr && (dcr_addr == WIN_ADDR);

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= '0;
    else if (idx_wr) idx_q <= dcr_wdata;
  end

  sdram_cfg_decode #(.NUM_BANKS(NUM_BANKS)) dec_i (
    .idx      (idx_q),
    .sel      (sel),
    .bank_hit (bank_hit)
  );

  sdram_cfg_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (win_wr),
    .wdata     (dcr_wdata),
    .sel       (sel),
    .err_set_a (err_set_a),
    .err_set_b (err_set_b),
    .errst_a_q (errst_a_q),
    .errst_b_q (errst_b_q),
    .erradr_q  (erradr_q),
    .gcfg_q    (gcfg_q),
    .gstat_q   (gstat_q),
    .rfsh_q    (rfsh_q),
    .idle_q    (idle_q),
    .ecccfg_q  (ecccfg_q),
    .eccerr_q  (eccerr_q),
    .irq_q     (ecc_irq)
  );

  sdram_cfg_banks #(.NUM_BANKS(NUM_BANKS)) banks_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (win_wr),
    .wdata    (dcr_wdata),
    .bank_hit (bank_hit),
    .bank_q   (bank_q)
  );

  always_comb begin
    win_data = '1;
    if (sel.errst_a) win_data = errst_a_q;
    if (sel.errst_b) win_data = errst_b_q;
    if (sel.erradr)  win_data = erradr_q;
    if (sel.gcfg)    win_data = gcfg_q;
    if (sel.gstat)   win_data = gstat_q;
    if (sel.rfsh)    win_data = rfsh_q;
    if (sel.idle)    win_data = idle_q;
    if (sel.timing)  win_data = '1;
    if (sel.ecccfg)  win_data = ecccfg_q;
    if (sel.eccerr)  win_data = eccerr_q;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) win_data = bank_q[b];
    end
  end

  always_comb begin
    if (dcr_addr == IDX_ADDR)      dcr_rdata = idx_q;
    else if (dcr_addr == WIN_ADDR) dcr_rdata = win_data;
    else                           dcr_rdata = '0;
  end

  assign mem_enable = gcfg_q[EN_BIT];
  assign bank_cfg   = bank_q;
endmodule

// File: rtl/sdram_cfg_checker.sv
module sdram_cfg_checker
  import sdram_cfg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned AW        = 10,
  parameter logic [AW-1:0] IDX_ADDR = 10'h010
) (
  input logic                       clk,
  input logic                       rst,
  input logic [AW-1:0]              dcr_addr,
  input logic                       dcr_wr,
  input logic                       win_wr,
  input logic [REG_W-1:0]           idx_q,
  input logic [REG_W-1:0]           gstat_q,
  input logic [REG_W-1:0]           idle_q,
  input logic [REG_W-1:0]           eccerr_q,
  input logic                       ecc_irq,
  input logic                       mem_enable,
  input logic [NUM_BANKS*REG_W-1:0] bank_cfg
);
  AST_INDEX_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(dcr_wr && dcr_addr == IDX_ADDR) |=> $stable(idx_q)); // R1

  AST_STATUS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (win_wr && idx_q == OFF_GSTAT) |=> $stable(gstat_q)); // R4

  AST_ENABLE_RISE_CLEARS_STATUS: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_enable) |-> !gstat_q[EN_BIT]); // R4

  AST_ENABLE_FALL_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_enable) |-> gstat_q[EN_BIT]); // R4

  AST_IDLE_LOW_FIELD: assert property (@(posedge clk) disable iff (rst)
    idle_q[26:0] == IDLE_FORCE[26:0]); // R6

  AST_IRQ_FOLLOWS_ECC: assert property (@(posedge clk) disable iff (rst)
    ecc_irq == (eccerr_q != '0)); // R7

  AST_BANK_MASKED: assert property (@(posedge clk) disable iff (rst)
    (bank_cfg & ~{NUM_BANKS{BANK_MASK}}) == '0); // R10
endmodule

bind sdram_cfg_regfile sdram_cfg_checker #(
  .NUM_BANKS (NUM_BANKS),
  .AW        (AW),
  .IDX_ADDR  (IDX_ADDR)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .dcr_addr   (dcr_addr),
  .dcr_wr     (dcr_wr),
  .win_wr     (win_wr),
  .idx_q      (idx_q),
  .gstat_q    (gstat_q),
  .idle_q     (idle_q),
  .eccerr_q   (eccerr_q),
  .ecc_irq    (ecc_irq),
  .mem_enable (mem_enable),
  .bank_cfg   (bank_cfg)
);

// File: tb/sdram_cfg_regfile_tb_top.sv
module sdram_cfg_regfile_tb_top;
  localparam int NB = 4;
  localparam logic [9:0] IDX = 10'h010;
  localparam logic [9:0] WIN = 10'h011;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic [9:0]    dcr_addr = '0;
  logic          dcr_wr = 1'b0;
  logic [31:0]   dcr_wdata = '0;
  logic [31:0]   dcr_rdata;
  logic [31:0]   err_set_a = '0;
  logic [31:0]   err_set_b = '0;
  logic          ecc_irq;
  logic          mem_enable;
  logic [NB*32-1:0] bank_cfg;

  sdram_cfg_regfile dut_i (
    .clk(clk), .rst(rst), .dcr_addr(dcr_addr), .dcr_wr(dcr_wr),
    .dcr_wdata(dcr_wdata), .dcr_rdata(dcr_rdata), .err_set_a(err_set_a),
    .err_set_b(err_set_b), .ecc_irq(ecc_irq), .mem_enable(mem_enable),
    .bank_cfg(bank_cfg)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural reference state
  logic [31:0] m_idx, m_ea, m_eb, m_adr, m_cfg, m_st, m_rf, m_idl, m_ecfg, m_eerr;
  logic [31:0] m_bank [NB];
  logic        m_irq;

  function automatic logic [31:0] m_win();
    if (m_idx == 32'h00) return m_ea;
    if (m_idx == 32'h08) return m_eb;
    if (m_idx == 32'h10) return m_adr;
    if (m_idx == 32'h20) return m_cfg;
    if (m_idx == 32'h24) return m_st;
    if (m_idx == 32'h30) return m_rf;
    if (m_idx == 32'h34) return m_idl;
    if (m_idx == 32'h94) return m_ecfg;
    if (m_idx == 32'h98) return m_eerr;
    for (int b = 0; b < NB; b++)
      if (m_idx == 32'h40 + 32'(4 * b)) return m_bank[b];
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] m_rd(input logic [9:0] a);
    if (a == IDX) return m_idx;
    if (a == WIN) return m_win();
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_idx = 0; m_ea = 0; m_eb = 0; m_adr = 0; m_cfg = 32'h0080_0000; m_st = 0;
      m_rf = 32'h05F0_0000; m_idl = 32'h07C0_0000; m_ecfg = 0; m_eerr = 0; m_irq = 0;
      for (int b = 0; b < NB; b++) m_bank[b] = 0;
    end else begin
      logic [31:0] ca, cb, v;
      ca = 0; cb = 0;
      if (dcr_wr && dcr_addr == WIN) begin
        case (m_idx)
          32'h00: ca = dcr_wdata;
          32'h08: cb = dcr_wdata;
          32'h10: m_adr = dcr_wdata;
          32'h20: begin
            v = dcr_wdata & 32'hFFE0_0000;
            if (!m_cfg[31] && v[31]) m_st[31] = 1'b0;
            else if (m_cfg[31] && !v[31]) m_st[31] = 1'b1;
            if (!m_cfg[30] && v[30]) m_st[30] = 1'b1;
            else if (m_cfg[30] && !v[30]) m_st[30] = 1'b0;
            m_cfg = v;
          end
          32'h30: m_rf = dcr_wdata & 32'h3FF8_0000;
          32'h34: m_idl = (dcr_wdata & 32'hF800_0000) | 32'h07C0_0000;
          32'h94: m_ecfg = dcr_wdata & 32'h00F0_0000;
          32'h98: begin
            v = dcr_wdata & 32'hFFF0_F000;
            if (m_eerr == 0 && v != 0) m_irq = 1'b1;
            else if (m_eerr != 0 && v == 0) m_irq = 1'b0;
            m_eerr = v;
          end
          default: begin
            for (int b = 0; b < NB; b++)
              if (m_idx == 32'h40 + 32'(4 * b)) m_bank[b] = dcr_wdata & 32'hFFDE_E001;
          end
        endcase
      end
      m_ea = (m_ea & ~ca) | err_set_a;
      m_eb = (m_eb & ~cb) | err_set_b;
      if (dcr_wr && dcr_addr == IDX) m_idx = dcr_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison of the continuously visible outputs
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(ecc_irq === m_irq, "R7 ecc_irq", 128'(ecc_irq), 128'(m_irq));
      chk(mem_enable === m_cfg[31], "R3 mem_enable", 128'(mem_enable), 128'(m_cfg[31]));
      for (int b = 0; b < NB; b++)
        chk(bank_cfg[b*32 +: 32] === m_bank[b], "R10 bank_cfg",
            128'(bank_cfg[b*32 +: 32]), 128'(m_bank[b]));
    end
  end

  task automatic cyc(input logic [9:0] a, input bit w, input logic [31:0] d);
    @(negedge clk);
    dcr_addr = a; dcr_wr = w; dcr_wdata = d; err_set_a = 0; err_set_b = 0;
  endtask

  task automatic pulse_err(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    dcr_wr = 0; err_set_a = a; err_set_b = b;
  endtask

  task automatic rd(input logic [9:0] a, input string tag);
    @(negedge clk);
    dcr_addr = a; dcr_wr = 0; err_set_a = 0; err_set_b = 0;
    #2;
    chk(dcr_rdata === m_rd(a), tag, 128'(dcr_rdata), 128'(m_rd(a)));
  endtask

  task automatic wr_win(input logic [31:0] off, input logic [31:0] d);
    cyc(IDX, 1, off);
    cyc(WIN, 1, d);
  endtask

  task automatic rd_win(input logic [31:0] off, input string tag);
    cyc(IDX, 1, off);
    rd(WIN, tag);
  endtask

  task automatic rd_fixed(input logic [31:0] off, input logic [31:0] exp, input string tag);
    cyc(IDX, 1, off);
    @(negedge clk);
    dcr_addr = WIN; dcr_wr = 0;
    #2;
    chk(dcr_rdata === exp, tag, 128'(dcr_rdata), 128'(exp));
  endtask

  logic [31:0] offs [16];

  initial begin
    offs = '{32'h00, 32'h08, 32'h10, 32'h20, 32'h24, 32'h30, 32'h34, 32'h40,
             32'h44, 32'h48, 32'h4C, 32'h80, 32'h94, 32'h98, 32'h0C, 32'h1_0020};
    repeat (3) @(negedge clk);
    rst = 0;

    // R8 reset values, checked against literal values
    rd(IDX, "R8 index reset");
    rd_fixed(32'h20, 32'h0080_0000, "R8 config reset");
    rd_fixed(32'h30, 32'h05F0_0000, "R8 refresh reset");
    rd_fixed(32'h34, 32'h07C0_0000, "R8 idle reset");
    rd_fixed(32'h98, 32'h0, "R8 ecc err reset");
    rd_fixed(32'h44, 32'h0, "R8 bank reset");

    // R1 index register and foreign port addresses
    cyc(IDX, 1, 32'hDEAD_BEEF);
    rd(IDX, "R1 index readback");
    rd(10'h012, "R1 foreign read zero");
    cyc(10'h012, 1, 32'h1234_5678);
    rd(IDX, "R1 foreign write ignored");
    cyc(10'h000, 1, 32'h20);
    rd(IDX, "R1 foreign write ignored 2");

    // R2 bus-error status and error address
    pulse_err(32'hF0F0_0001, 32'h0000_FF00);
    rd_win(32'h00, "R2 err A set");
    rd_win(32'h08, "R2 err B set");
    wr_win(32'h00, 32'h3030_0000);
    rd_win(32'h00, "R2 err A write-one-clear");
    wr_win(32'h08, 32'h0000_0000);
    rd_win(32'h08, "R2 err B zero write keeps");
    cyc(IDX, 1, 32'h00);
    @(negedge clk);
    dcr_addr = WIN; dcr_wr = 1; dcr_wdata = 32'hFFFF_FFFF; err_set_a = 32'h8; err_set_b = 0;
    rd(WIN, "R2 set wins over clear");
    wr_win(32'h10, 32'hCAFE_F00D);
    rd_win(32'h10, "R2 error address rw");

    // R3/R4 configuration and status edges
    wr_win(32'h20, 32'hC01F_FFFF);
    rd_win(32'h20, "R3 config mask");
    rd_win(32'h24, "R4 status after enable");
    wr_win(32'h24, 32'hFFFF_FFFF);
    rd_win(32'h24, "R4 status read-only");
    wr_win(32'h20, 32'h0000_0000);
    rd_win(32'h24, "R4 status after disable");
    wr_win(32'h20, 32'h8000_0000);
    rd_win(32'h24, "R4 status re-enable");

    // R5/R6 masks
    wr_win(32'h30, 32'hFFFF_FFFF);
    rd_win(32'h30, "R5 refresh mask");
    wr_win(32'h94, 32'hFFFF_FFFF);
    rd_win(32'h94, "R5 ecc cfg mask");
    wr_win(32'h34, 32'h0000_0000);
    rd_win(32'h34, "R6 idle zero write");
    wr_win(32'h34, 32'hFFFF_FFFF);
    rd_fixed(32'h34, 32'hFFC0_0000, "R6 idle ones write");

    // R7 interrupt transitions
    wr_win(32'h98, 32'h0000_F000);
    rd_win(32'h98, "R7 ecc err set");
    wr_win(32'h98, 32'hFFFF_FFFF);
    rd_win(32'h98, "R7 ecc err nonzero to nonzero");
    wr_win(32'h98, 32'h000F_0FFF);
    rd_win(32'h98, "R7 ecc err masked to zero");

    // R9 timing and unknown offsets
    wr_win(32'h80, 32'h1234_5678);
    rd_fixed(32'h80, 32'hFFFF_FFFF, "R9 timing reads ones");
    wr_win(32'h0C, 32'h0);
    rd_fixed(32'h0C, 32'hFFFF_FFFF, "R9 unknown reads ones");
    for (int k = 0; k < 14; k++) rd_win(offs[k], "R9 unknown write ignored");

    // R10 bank words
    for (int b = 0; b < NB; b++) wr_win(32'h40 + 32'(4 * b), 32'hFFFF_FFFF - 32'(b));
    for (int b = 0; b < NB; b++) rd_win(32'h40 + 32'(4 * b), "R10 bank readback");

    // Mixed traffic
    for (int k = 0; k < 400; k++) begin
      if ((k % 9) == 0) pulse_err($urandom, $urandom);
      wr_win(offs[$urandom % 16], $urandom);
      rd_win(offs[$urandom % 16], "R2 mixed traffic read");
    end

    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule